// File: doc/BRIEF.md
# Converter Result Serial Readout Port

This block presents a finished conversion word on a single serial data line. When a result-ready strobe arrives, the word is formatted, held, and copied into a shift register. The bits then go out most significant first, either under a bit clock the block makes itself (master mode) or under a bit clock supplied by the host (slave mode). In master mode a frame-sync output marks the read, and its polarity can be selected. In slave mode, one input picks which host clock edge moves the data. A one-cycle error pulse is raised when a new result arrives in the middle of a slave read.

The host enables the port by holding chip select and read enable low together. Raising chip select cancels any read in progress and rewinds the word, so the next read starts again at the top bit. Everything runs on the system clock. The host bit clock is brought in through a two-stage synchronizer, and its edges are detected in the system clock domain, so the host bit clock must be much slower than the system clock.

Top module: `adc_serial_readout`

## Requirements
- R1: A full read shifts out all DATA_W bits of the held word, most significant bit first, on `sdo_o`.
- R2: When `twos_fmt_i` is 1, the top bit of the result is inverted before it is held and the lower bits pass through unchanged. When it is 0, the word passes through unchanged.
- R3: `sdo_oe_o` is 1 exactly one system clock after `cs_n_i` and `rd_n_i` are both 0. Otherwise it is 0.
- R4: While `cs_n_i` is 1, host clock edges shift nothing, the bit count returns to zero, and `sdo_o` shows the top bit of the held word. A read that follows therefore starts over at the top bit.
- R5: In slave mode (`ext_clk_i`=1), the update edge of `sclk_i` presents the next bit and the opposite edge samples it. The update edge is the rising edge when `inv_edge_i`=0 and the falling edge when `inv_edge_i`=1. `sdo_o` does not change on a sample edge.
- R6: In master mode (`ext_clk_i`=0), each read drives `sclk_o` through exactly DATA_W rising edges. The period is 2*CLK_HALF system clocks. `sclk_o` idles low, and data is stable across each rising edge.
- R7: In master mode, `sync_o` is active while `sclk_o` pulses. Its active level is 1 when `inv_sync_i`=0 and 0 when `inv_sync_i`=1. When idle, `sync_o` equals `inv_sync_i`.
- R8: In slave mode, suppose a read has started (at least one host clock edge) but not finished, and a result strobe arrives. Then `rd_err_o` pulses high for exactly one cycle, and the new word replaces the partial one. The next read returns the new word from its top bit.
- R9: A result strobe during a master read is ignored: the read completes with the old word and no error is raised. A slave-mode strobe before any host clock edge reloads the word without an error.
- R10: After reset, `sclk_o`, `rd_err_o` and `sdo_oe_o` are 0, and `sync_o` is at its idle level.
- R11: A master read starts only while the port is enabled and an unread result is pending. Each result is read once, and re-enabling the port does not start another read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| result_i | input | DATA_W | Conversion result word |
| result_vld_i | input | 1 | One-cycle result-ready strobe |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read enable, active low |
| ext_clk_i | input | 1 | 1 = host supplies bit clock (slave), 0 = internal clock (master) |
| inv_edge_i | input | 1 | Slave update edge: 0 = rising, 1 = falling |
| inv_sync_i | input | 1 | Frame-sync polarity: 0 = active high, 1 = active low |
| twos_fmt_i | input | 1 | 1 = two's complement (top bit inverted), 0 = offset binary |
| sclk_i | input | 1 | Host bit clock for slave mode |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data line |
| sclk_o | output | 1 | Generated bit clock for master mode |
| sync_o | output | 1 | Frame sync for master mode |
| rd_err_o | output | 1 | Incomplete-read error pulse |

## Verification
On every cycle, the assertions check the following:
- the error pulse lasts a single cycle and appears only in slave mode;
- frame sync is active whenever the generated clock is high;
- the generated clock never exceeds DATA_W rising edges and stays low when idle;
- the bit count is cleared after any cycle with chip select high.

Other behaviours can only be shown by the bench's scenarios, because they depend on a whole read:
- the bit order of a complete word and the format conversion;
- the choice of update edge;
- rewinding to the top bit after chip select is raised;
- the content delivered after an overrun;
- ignoring a strobe during a master read;
- not starting a second master read for the same result.

// File: rtl/srd_pkg.sv
package srd_pkg;

  // Strobes that move the shift register: smp consumes a bit, upd presents the next
  typedef struct packed {
    logic smp;
    logic upd;
  } srd_strobe_t;

endpackage

// File: rtl/srd_edge_det.sv
module srd_edge_det
  import srd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk_i,
  input  logic        inv_edge_i,
  output srd_strobe_t stb_o
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic               rise, fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[0], sclk_i};
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN_W-2:0], sclk_i};
      end
    end
  endgenerate

  assign rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
  assign fall = ~chain_q[CHAIN_W-2] & chain_q[CHAIN_W-1];

  always_comb begin
    stb_o.upd = inv_edge_i ? fall : rise;
    stb_o.smp = inv_edge_i ? rise : fall;
  end

endmodule

// File: rtl/srd_mclk_gen.sv
module srd_mclk_gen
  import srd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CLK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        abort_i,
  output logic        sclk_o,
  output srd_strobe_t stb_o,
  output logic        busy_o,
  output logic        done_o
);

  localparam int DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int RC_W  = $clog2(DATA_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);
  localparam logic [RC_W-1:0]  RC_FULL  = RC_W'(DATA_W);

  logic             run_q, sclk_q;
  logic [DIV_W-1:0] div_q;
  logic [RC_W-1:0]  rise_cnt_q;
  logic             tick;

  assign tick      = run_q && (div_q == DIV_LAST);
  assign stb_o.smp = tick && !sclk_q;
  assign stb_o.upd = tick && sclk_q;
  assign done_o    = stb_o.upd && (rise_cnt_q == RC_FULL);

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      run_q      <= 1'b0;
      sclk_q     <= 1'b0;
      div_q      <= '0;
      rise_cnt_q <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q      <= 1'b1;
        div_q      <= '0;
        rise_cnt_q <= '0;
        sclk_q     <= 1'b0;
      end
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        sclk_q <= ~sclk_q;
        if (!sclk_q) rise_cnt_q <= rise_cnt_q + 1'b1;
        if (done_o)  run_q      <= 1'b0;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign busy_o = run_q;

  // R6
  mclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !sclk_q);

  // R6
  mclk_rise_limit_chk: assert property (@(posedge clk) disable iff (rst)
    rise_cnt_q <= RC_FULL);

endmodule

// File: rtl/srd_shifter.sv
module srd_shifter
  import srd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              cs_n_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  srd_strobe_t       stb_i,
  output logic              sdo_o,
  output logic              active_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] word_q, sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              started_q, sdo_q, room;

  assign room = (cnt_q < CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      sh_q      <= '0;
      sdo_q     <= 1'b0;
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (load_i) begin
      word_q    <= word_i;
      sh_q      <= word_i;
      sdo_q     <= word_i[DATA_W-1];
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (cs_n_i) begin
      sh_q      <= word_q;
      sdo_q     <= word_q[DATA_W-1];
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (en_i && room) begin
      if (stb_i.upd) begin
        sdo_q     <= sh_q[DATA_W-1];
        started_q <= 1'b1;
      end
      if (stb_i.smp) begin
        sh_q      <= {sh_q[DATA_W-2:0], 1'b0};
        cnt_q     <= cnt_q + 1'b1;
        started_q <= 1'b1;
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign active_o = started_q && room;

  // R4
  cs_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> (cnt_q == '0));

  // R1
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);

endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
  import srd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CLK_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_vld_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              ext_clk_i,
  input  logic              inv_edge_i,
  input  logic              inv_sync_i,
  input  logic              twos_fmt_i,
  input  logic              sclk_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              rd_err_o
);

  logic              en, overrun, load, read_busy, pending_q;
  logic              m_start, m_abort, m_busy, m_done, sh_active;
  logic [DATA_W-1:0] word_fmt;
  srd_strobe_t       e_stb, m_stb, stb;
  logic              sdo_oe_q, sync_q, err_q;

  assign en       = !cs_n_i && !rd_n_i;
  assign word_fmt = {result_i[DATA_W-1] ^ twos_fmt_i, result_i[DATA_W-2:0]};

  assign read_busy = ext_clk_i ? sh_active : m_busy;
  assign overrun   = ext_clk_i && sh_active && result_vld_i;
  assign load      = result_vld_i && (!read_busy || overrun);
  assign m_start   = !ext_clk_i && en && pending_q && !load;
  assign m_abort   = cs_n_i || ext_clk_i;
  assign stb       = ext_clk_i ? e_stb : m_stb;

  srd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .sclk_i    (sclk_i),
    .inv_edge_i(inv_edge_i),
    .stb_o     (e_stb)
  );

  srd_mclk_gen #(.DATA_W(DATA_W), .CLK_HALF(CLK_HALF)) u_mclk (
    .clk    (clk),
    .rst    (rst),
    .start_i(m_start),
    .abort_i(m_abort),
    .sclk_o (sclk_o),
    .stb_o  (m_stb),
    .busy_o (m_busy),
    .done_o (m_done)
  );

  srd_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en),
    .cs_n_i  (cs_n_i),
    .load_i  (load),
    .word_i  (word_fmt),
    .stb_i   (stb),
    .sdo_o   (sdo_o),
    .active_o(sh_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      sdo_oe_q  <= 1'b0;
      sync_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (load)        pending_q <= 1'b1;
      else if (m_done) pending_q <= 1'b0;
      sdo_oe_q <= en;
      sync_q   <= inv_sync_i ^ (m_busy && !ext_clk_i);
      err_q    <= overrun;
    end
  end

  assign sdo_oe_o = sdo_oe_q;
  assign sync_o   = sync_q;
  assign rd_err_o = err_q;

  // R8
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err_o |=> !rd_err_o);

  // R8
  err_slave_only_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err_o |-> $past(ext_clk_i));

  // R7
  sync_covers_clk_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> (sync_o != inv_sync_i));

endmodule

// File: tb/adc_serial_readout_bench.sv
`timescale 1ns/1ps
module adc_serial_readout_bench;

  localparam int W  = 16;
  localparam int MH = 4;
  localparam int SH = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] result_i = '0;
  logic         result_vld_i = 1'b0;
  logic         cs_n_i = 1'b1, rd_n_i = 1'b1;
  logic         ext_clk_i = 1'b1, inv_edge_i = 1'b0, inv_sync_i = 1'b0;
  logic         twos_fmt_i = 1'b0, sclk_i = 1'b0;
  logic         sdo_o, sdo_oe_o, sclk_o, sync_o, rd_err_o;

  int n_tests = 0, n_fail = 0, err_seen = 0;

  always #2.5 clk = ~clk;

  adc_serial_readout #(.DATA_W(W), .CLK_HALF(MH)) u_adc_serial_readout (
    .clk(clk), .rst(rst), .result_i(result_i), .result_vld_i(result_vld_i),
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .ext_clk_i(ext_clk_i),
    .inv_edge_i(inv_edge_i), .inv_sync_i(inv_sync_i), .twos_fmt_i(twos_fmt_i),
    .sclk_i(sclk_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .sclk_o(sclk_o),
    .sync_o(sync_o), .rd_err_o(rd_err_o)
  );

  always @(negedge clk) if (!rst && rd_err_o) err_seen++;

  function automatic logic [W-1:0] fmt(logic [W-1:0] w, logic twos);
    return {w[W-1] ^ twos, w[W-2:0]};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [W-1:0] w);
    result_i = w; result_vld_i = 1'b1;
    tick(1);
    result_vld_i = 1'b0;
  endtask

  task automatic setup(logic ext, logic inv_e, logic inv_s, logic twos);
    cs_n_i = 1'b1; rd_n_i = 1'b1;
    ext_clk_i = ext; inv_edge_i = inv_e; inv_sync_i = inv_s; twos_fmt_i = twos;
    sclk_i = inv_e;
    tick(6);
  endtask

  // Drives n host clock cycles; collects sampled bits and counts sdo changes on sample edges
  task automatic slave_bits(int n, output logic [W-1:0] w, output int moved);
    logic b;
    w = '0; moved = 0;
    for (int k = 0; k < n; k++) begin
      sclk_i = ~inv_edge_i;
      tick(SH);
      b = sdo_o;
      w = {w[W-2:0], b};
      sclk_i = inv_edge_i;
      tick(SH);
      if (sdo_o !== b) moved++;
    end
  endtask

  task automatic master_read(int inject_at, logic [W-1:0] inj,
                             output logic [W-1:0] w, output int nrise,
                             output int per_bad, output int sync_bad);
    int cyc, last;
    logic prev;
    w = '0; nrise = 0; per_bad = 0; sync_bad = 0; cyc = 0; last = 0;
    prev = sclk_o;
    while (cyc < 40 * W * MH + 100) begin
      tick(1);
      result_vld_i = 1'b0;
      cyc++;
      if (sclk_o && !prev) begin
        w = {w[W-2:0], sdo_o};
        if (nrise > 0 && (cyc - last) != 2 * MH) per_bad++;
        last = cyc;
        nrise++;
        if (inject_at != 0 && nrise == inject_at) begin
          result_i = inj; result_vld_i = 1'b1;
        end
      end
      if (sclk_o && sync_o == inv_sync_i) sync_bad++;
      prev = sclk_o;
      if (nrise >= W && !sclk_o && sync_o == inv_sync_i) break;
    end
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] w, a, b;
    int moved, nr, pb, sb, e0, seed;
    seed = $urandom(32'd2718);

    tick(4);
    rst = 1'b0;
    tick(2);
    // R10 reset state
    check("R10 sclk_o", sclk_o, 0);
    check("R10 rd_err_o", rd_err_o, 0);
    check("R10 sdo_oe_o", sdo_oe_o, 0);
    check("R10 sync_o idle", sync_o, 0);

    // R3 output enable needs both selects low
    cs_n_i = 0; rd_n_i = 1; tick(2);
    check("R3 cs only", sdo_oe_o, 0);
    cs_n_i = 1; rd_n_i = 0; tick(2);
    check("R3 rd only", sdo_oe_o, 0);
    cs_n_i = 0; tick(2);
    check("R3 both low", sdo_oe_o, 1);

    // R1 offset binary, MSB first
    setup(1, 0, 0, 0);
    strobe(16'hA5C3);
    cs_n_i = 0; rd_n_i = 0; tick(2);
    slave_bits(W, w, moved);
    check("R1 msb first", w, 16'hA5C3);
    check("R5 rising update stable", moved, 0);

    // R2 two's complement inverts the top bit
    setup(1, 0, 0, 1);
    strobe(16'hA5C3);
    cs_n_i = 0; rd_n_i = 0; tick(2);
    slave_bits(W, w, moved);
    check("R2 twos format", w, 16'h25C3);

    // R5 falling-edge update
    setup(1, 1, 0, 0);
    strobe(16'h3C96);
    cs_n_i = 0; rd_n_i = 0; tick(2);
    slave_bits(W, w, moved);
    check("R5 falling update word", w, 16'h3C96);
    check("R5 falling update stable", moved, 0);

    // R4 chip select rewinds and gates the clock
    setup(1, 0, 0, 0);
    strobe(16'hF00D);
    cs_n_i = 0; rd_n_i = 0; tick(2);
    slave_bits(6, w, moved);
    cs_n_i = 1;
    tick(2);
    check("R4 oe off under cs", sdo_oe_o, 0);
    for (int k = 0; k < 3; k++) begin
      sclk_i = 1; tick(SH); sclk_i = 0; tick(SH);
    end
    check("R4 sdo shows msb", sdo_o, 1);
    cs_n_i = 0; tick(2);
    slave_bits(W, w, moved);
    check("R4 restart at msb", w, 16'hF00D);

    // R8 overrun during slave read
    setup(1, 0, 0, 0);
    strobe(16'h1234);
    cs_n_i = 0; rd_n_i = 0; tick(2);
    slave_bits(5, w, moved);
    e0 = err_seen;
    strobe(16'hBEEF);
    tick(3);
    check("R8 one error pulse", err_seen - e0, 1);
    slave_bits(W, w, moved);
    check("R8 new word delivered", w, 16'hBEEF);

    // R9 slave strobe before any edge reloads silently
    setup(1, 0, 0, 0);
    strobe(16'h0F0F);
    cs_n_i = 0; rd_n_i = 0; tick(2);
    e0 = err_seen;
    strobe(16'hC0DE);
    tick(3);
    check("R9 no error before edges", err_seen - e0, 0);
    slave_bits(W, w, moved);
    check("R9 slave reload", w, 16'hC0DE);

    // R6 R7 master read, sync active high
    setup(0, 0, 0, 0);
    strobe(16'h9A7B);
    cs_n_i = 0; rd_n_i = 0;
    master_read(0, '0, w, nr, pb, sb);
    check("R6 master word", w, 16'h9A7B);
    check("R6 rise count", nr, W);
    check("R6 period", pb, 0);
    check("R7 sync active high", sb, 0);
    check("R7 sync idle", sync_o, 0);

    // R7 inverted sync; R9 strobe during master read ignored
    setup(0, 0, 1, 0);
    strobe(16'h5555);
    cs_n_i = 0; rd_n_i = 0;
    e0 = err_seen;
    master_read(5, 16'hAAAA, w, nr, pb, sb);
    check("R9 master ignores strobe", w, 16'h5555);
    check("R9 no error in master", err_seen - e0, 0);
    check("R7 sync active low", sb, 0);
    check("R7 sync idle high", sync_o, 1);

    // R11 no second read for the same result
    cs_n_i = 1; tick(4); cs_n_i = 0;
    nr = 0;
    for (int k = 0; k < 100; k++) begin
      tick(1);
      if (sclk_o) nr++;
    end
    check("R11 no repeat read", nr, 0);

    // Random mix of modes, formats and edges
    for (int it = 0; it < 24; it++) begin
      logic m, ie, is, tw;
      m = 1'($urandom); ie = 1'($urandom); is = 1'($urandom); tw = 1'($urandom);
      a = W'($urandom);
      setup(m, ie, is, tw);
      strobe(a);
      cs_n_i = 0; rd_n_i = 0;
      if (m) begin
        tick(2);
        slave_bits(W, w, moved);
        check("R1 R5 random slave", w, fmt(a, tw));
      end else begin
        master_read(0, '0, w, nr, pb, sb);
        check("R6 random master", w, fmt(a, tw));
        check("R6 random rises", nr, W);
        check("R7 random sync", sb, 0);
      end
    end
    b = '0;
    check("R2 fmt self", fmt(b, 1), 16'h8000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule